// File: doc/BRIEF.md
# Triangle Tessellation Vertex Generator

This block turns one triangle-domain patch request into the ordered stream of barycentric vertex positions that tessellation with equal spacing produces. A request carries an inner level and one level for each of the three outer edges. The block first walks the outer triangle edge by edge, then a series of concentric triangles, each smaller than the last, until it reaches the centre. Each vertex is a triple of unsigned fixed-point values with 1 integer bit and 15 fraction bits, so ONE is 32768. At most one vertex leaves per cycle.

Internally a setup stage prepares one ring description at a time: its corner values and its per-edge step. It reads reciprocals from a lookup table and multiplies by them, so it needs no divider. It gets the large corner component from the constant sum of each corner rather than from a further multiply. A generation stage steps along the edges of the ring it holds with a single accumulator, while setup prepares the next ring. The request side and the vertex side both use valid/ready handshakes. The last vertex of a patch carries an end flag.

Top module: `tess_tri_gen`

## Requirements
- R1: After reset `vtx_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from then until the vertex flagged `vtx_eop` has been accepted. It is high again on the cycle after that acceptance.
- R3: With R(n) = floor(32768/n), the outer ring comes first. Edge k (k = 0, 1, 2) runs from corner k to corner (k+1) mod 3, where corner k has ONE in component k and 0 elsewhere. It emits outer-level-k vertices for j = 0 .. level-1. Each has component k = ONE - j*R(level), component (k+1) mod 3 = j*R(level), and 0 in the third component. Components are ordered u, v, w.
- R4: Inner rings follow with segment counts m = n-2, n-4, ... while m >= 0, where n is the inner level. An inner level of 1 gives no inner ring.
- R5: A ring of count m has corner values: scale = m*R(n), b = ((ONE - scale)*10922) >> 15, a = ONE - 2b. Its corner k has a in component k and b in the other two.
- R6: A ring with m >= 1 emits 3m vertices over its three edges, in the same edge order as R3. With s = ((a-b)*R(m)) >> 15, vertex j of edge k has component k = a - j*s, component (k+1) mod 3 = b + j*s, and b in the third component.
- R7: A ring with m = 1 emits only its three corners. A ring with m = 0 emits one vertex (a, b, b), which is (10924, 10922, 10922).
- R8: A patch emits exactly the vertices of R3 through R7, in that order, each exactly once.
- R9: `vtx_eop` is 1 only on the final vertex of a patch.
- R10: While `vtx_valid` is high and `vtx_ready` is low, the vertex and its flag hold steady and stay valid.
- R11: A level of 0 is treated as 1. A level above 64 is treated as 64.
- R12: The three components of every emitted vertex sum to exactly ONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Patch request present |
| req_ready | output | 1 | Block can take a request |
| req_inner | input | 7 | Inner level |
| req_outer0 | input | 7 | Level of outer edge 0 (corner 0 to 1) |
| req_outer1 | input | 7 | Level of outer edge 1 (corner 1 to 2) |
| req_outer2 | input | 7 | Level of outer edge 2 (corner 2 to 0) |
| vtx_valid | output | 1 | Vertex present |
| vtx_ready | input | 1 | Consumer takes the vertex |
| vtx_u | output | 16 | Component 0, 1.15 fixed point |
| vtx_v | output | 16 | Component 1, 1.15 fixed point |
| vtx_w | output | 16 | Component 2, 1.15 fixed point |
| vtx_eop | output | 1 | Final vertex of the patch |

## Verification
On every cycle the assertions check that a vertex's components sum to ONE, that a stalled vertex holds still, that the request side stays closed while vertices flow, and that the end flag only appears with a valid vertex. The exact ring geometry cannot be seen from a single cycle: rounding of reciprocals, corner values, step sizes, edge order, ring count and centre handling all need a known patch. Those, together with clamping, the exact vertex count and backpressure patterns, are shown only by the bench sweeping many level combinations against arithmetic expectations.

// File: rtl/tess_pkg.sv
package tess_pkg;
    localparam int CW   = 16;
    localparam int FRAC = 15;
    localparam int LW   = 7;
    localparam int MAXL = 64;
    localparam logic [CW-1:0] ONE   = CW'(1 << FRAC);
    localparam logic [CW-1:0] THIRD = CW'((1 << FRAC) / 3);

    typedef struct packed {
        logic [CW-1:0]         a;
        logic [CW-1:0]         b;
        logic [2:0][CW-1:0]    step;
        logic [2:0][LW-1:0]    segs;
        logic                  centre;
        logic                  last;
    } ring_t;

    function automatic logic [LW-1:0] clamp_level(input logic [LW-1:0] x);
        if (x == '0)
            return LW'(1);
        else if (int'(x) > MAXL)
            return LW'(MAXL);
        else
            return x;
    endfunction
endpackage

// File: rtl/tess_recip_rom.sv
module tess_recip_rom
    import tess_pkg::*;
#(
    parameter int MAXN = MAXL
) (
    input  logic [LW-1:0] idx,
    output logic [CW-1:0] recip
);
    logic [CW-1:0] tbl [MAXN+1];

    for (genvar i = 0; i <= MAXN; i++) begin : g_ent
        assign tbl[i] = (i == 0) ? '0 : CW'((1 << FRAC) / i);
    end

    assign recip = (int'(idx) <= MAXN) ? tbl[idx] : '0;
endmodule

// File: rtl/tess_mul.sv
module tess_mul
    import tess_pkg::*;
#(
    parameter int SHIFT = FRAC
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic [CW-1:0] p
);
    localparam int PW = 2 * CW;
    assign p = CW'((PW'(x) * PW'(y)) >> SHIFT);
endmodule

// File: rtl/tess_setup.sv
module tess_setup
    import tess_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LW-1:0]      lvl_in,
    input  logic [2:0][LW-1:0] lvl_out,
    input  logic               desc_take,
    output ring_t              desc,
    output logic               desc_valid,
    output logic               idle
);
    typedef enum logic [2:0] {
        SU_IDLE, SU_OUTER, SU_MUL1, SU_MUL2, SU_MUL3, SU_HOLD
    } su_st_e;

    typedef struct packed {
        su_st_e             st;
        logic [1:0]         cnt;
        logic               outer;
        logic [LW-1:0]      n;
        logic [2:0][LW-1:0] o;
        logic [LW-1:0]      m;
        logic [CW-1:0]      scale;
        ring_t              r;
    } su_t;

    su_t su_d, su_q;

    logic [LW-1:0] rom_idx;
    logic [CW-1:0] rom_val;
    logic [CW-1:0] mi_x, mi_p;   // integer-scaled multiplier
    logic [CW-1:0] mf_x, mf_y, mf_p; // fraction-scaled multiplier

    tess_recip_rom #(.MAXN(MAXL)) rom_i (.idx(rom_idx), .recip(rom_val));
    tess_mul #(.SHIFT(0))    mul_int_i  (.x(mi_x), .y(rom_val), .p(mi_p));
    tess_mul #(.SHIFT(FRAC)) mul_frac_i (.x(mf_x), .y(mf_y),    .p(mf_p));

    always_comb begin
        su_d    = su_q;
        rom_idx = '0;
        mi_x    = '0;
        mf_x    = '0;
        mf_y    = '0;
        case (su_q.st)
            SU_IDLE: begin
                if (start) begin
                    su_d.n     = clamp_level(lvl_in);
                    for (int k = 0; k < 3; k++)
                        su_d.o[k] = clamp_level(lvl_out[k]);
                    su_d.cnt   = '0;
                    su_d.outer = 1'b1;
                    su_d.st    = SU_OUTER;
                end
            end
            SU_OUTER: begin
                rom_idx                = su_q.o[su_q.cnt];
                su_d.r.step[su_q.cnt]  = rom_val;
                su_d.r.segs[su_q.cnt]  = su_q.o[su_q.cnt];
                su_d.r.a               = ONE;
                su_d.r.b               = '0;
                su_d.r.centre          = 1'b0;
                su_d.r.last            = (su_q.n < LW'(2));
                su_d.cnt               = su_q.cnt + 2'd1;
                if (su_q.cnt == 2'd2)
                    su_d.st = SU_HOLD;
            end
            SU_MUL1: begin
                rom_idx    = su_q.n;
                mi_x       = CW'(su_q.m);
                su_d.scale = mi_p;
                su_d.st    = SU_MUL2;
            end
            SU_MUL2: begin
                mf_x     = ONE - su_q.scale;
                mf_y     = THIRD;
                su_d.r.b = mf_p;
                // corner sum per vertex is ONE: large term follows from the two small ones
                su_d.r.a = ONE - mf_p - mf_p;
                su_d.st  = SU_MUL3;
            end
            SU_MUL3: begin
                rom_idx = su_q.m;
                mf_x    = su_q.r.a - su_q.r.b;
                mf_y    = rom_val;
                for (int k = 0; k < 3; k++) begin
                    su_d.r.step[k] = mf_p;
                    su_d.r.segs[k] = su_q.m;
                end
                su_d.r.centre = (su_q.m == '0);
                su_d.r.last   = (su_q.m < LW'(2));
                su_d.st       = SU_HOLD;
            end
            SU_HOLD: begin
                if (desc_take) begin
                    if (su_q.r.last) begin
                        su_d.st = SU_IDLE;
                    end else begin
                        su_d.m     = su_q.outer ? (su_q.n - LW'(2)) : (su_q.m - LW'(2));
                        su_d.outer = 1'b0;
                        su_d.st    = SU_MUL1;
                    end
                end
            end
            default: su_d.st = SU_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            su_q    <= '0;
            su_q.st <= SU_IDLE;
        end else begin
            su_q <= su_d;
        end
    end

    assign desc       = su_q.r;
    assign desc_valid = (su_q.st == SU_HOLD);
    assign idle       = (su_q.st == SU_IDLE);
endmodule

// File: rtl/tess_walk.sv
module tess_walk
    import tess_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ring_t              desc,
    input  logic               desc_valid,
    output logic               desc_take,
    output logic               vtx_valid,
    input  logic               vtx_ready,
    output logic [2:0][CW-1:0] vtx,
    output logic               vtx_eop,
    output logic               busy
);
    typedef struct packed {
        logic          busy;
        ring_t         ring;
        logic [1:0]    k;
        logic [LW-1:0] j;
        logic [CW-1:0] acc;
    } wk_t;

    wk_t wk_d, wk_q;

    logic       fire, edge_end, ring_end;
    logic [1:0] k_nxt;

    always_comb begin
        k_nxt    = (wk_q.k == 2'd2) ? 2'd0 : wk_q.k + 2'd1;
        fire     = wk_q.busy && vtx_ready;
        edge_end = (wk_q.j == wk_q.ring.segs[wk_q.k] - LW'(1));
        ring_end = wk_q.ring.centre || (edge_end && wk_q.k == 2'd2);

        for (int c = 0; c < 3; c++) begin
            if (wk_q.ring.centre)
                vtx[c] = (c == 0) ? wk_q.ring.a : wk_q.ring.b;
            else if (2'(c) == wk_q.k)
                vtx[c] = wk_q.ring.a - wk_q.acc;
            else if (2'(c) == k_nxt)
                vtx[c] = wk_q.ring.b + wk_q.acc;
            else
                vtx[c] = wk_q.ring.b;
        end

        desc_take = desc_valid && (!wk_q.busy || (fire && ring_end));

        wk_d = wk_q;
        if (fire) begin
            if (ring_end) begin
                wk_d.busy = 1'b0;
            end else if (edge_end) begin
                wk_d.k   = k_nxt;
                wk_d.j   = '0;
                wk_d.acc = '0;
            end else begin
                wk_d.j   = wk_q.j + LW'(1);
                wk_d.acc = wk_q.acc + wk_q.ring.step[wk_q.k];
            end
        end
        if (desc_take) begin
            wk_d.busy = 1'b1;
            wk_d.ring = desc;
            wk_d.k    = '0;
            wk_d.j    = '0;
            wk_d.acc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wk_q <= '0;
        else
            wk_q <= wk_d;
    end

    assign vtx_valid = wk_q.busy;
    assign vtx_eop   = wk_q.busy && wk_q.ring.last && ring_end;
    assign busy      = wk_q.busy;
endmodule

// File: rtl/tess_tri_gen.sv
module tess_tri_gen
    import tess_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [LW-1:0] req_inner,
    input  logic [LW-1:0] req_outer0,
    input  logic [LW-1:0] req_outer1,
    input  logic [LW-1:0] req_outer2,
    output logic          vtx_valid,
    input  logic          vtx_ready,
    output logic [CW-1:0] vtx_u,
    output logic [CW-1:0] vtx_v,
    output logic [CW-1:0] vtx_w,
    output logic          vtx_eop
);
    ring_t              desc;
    logic               desc_valid, desc_take, su_idle, wk_busy;
    logic [2:0][CW-1:0] vtx;

    assign req_ready = su_idle && !wk_busy;

    tess_setup setup_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid && req_ready),
        .lvl_in    (req_inner),
        .lvl_out   ({req_outer2, req_outer1, req_outer0}),
        .desc_take (desc_take),
        .desc      (desc),
        .desc_valid(desc_valid),
        .idle      (su_idle)
    );

    tess_walk walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .desc      (desc),
        .desc_valid(desc_valid),
        .desc_take (desc_take),
        .vtx_valid (vtx_valid),
        .vtx_ready (vtx_ready),
        .vtx       (vtx),
        .vtx_eop   (vtx_eop),
        .busy      (wk_busy)
    );

    assign vtx_u = vtx[0];
    assign vtx_v = vtx[1];
    assign vtx_w = vtx[2];
endmodule

// File: rtl/tess_tri_gen_chk.sv
module tess_tri_gen_chk
    import tess_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          vtx_valid,
    input logic          vtx_ready,
    input logic [CW-1:0] vtx_u,
    input logic [CW-1:0] vtx_v,
    input logic [CW-1:0] vtx_w,
    input logic          vtx_eop
);
    assert_sum_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vtx_valid |-> ((18'(vtx_u) + 18'(vtx_v) + 18'(vtx_w)) == 18'(ONE)));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vtx_valid && !vtx_ready) |=> (vtx_valid && $stable(vtx_u) && $stable(vtx_v)
                                       && $stable(vtx_w) && $stable(vtx_eop)));

    assert_closed_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vtx_valid |-> !req_ready);

    assert_closed_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_eop_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vtx_eop |-> vtx_valid);
endmodule

bind tess_tri_gen tess_tri_gen_chk chk_i (.*);

// File: tb/tess_tri_gen_tb.sv
module tess_tri_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [6:0]  req_inner = '0, req_outer0 = '0, req_outer1 = '0, req_outer2 = '0;
    logic        vtx_valid;
    logic        vtx_ready = 1'b0;
    logic [15:0] vtx_u, vtx_v, vtx_w;
    logic        vtx_eop;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [48:0] exp_q[$];
    string       tag_q[$];
    string       tag_ovr = "";

    always #2 clk = ~clk;

    tess_tri_gen dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int rcp(input int n);
        return (n <= 0) ? 0 : 32768 / n;
    endfunction

    function automatic int clampl(input int x);
        return (x == 0) ? 1 : ((x > 64) ? 64 : x);
    endfunction

    task automatic push(input int c0, c1, c2, input string tg);
        exp_q.push_back({1'b0, 16'(c2), 16'(c1), 16'(c0)});
        tag_q.push_back(tag_ovr != "" ? tag_ovr : tg);
    endtask

    task automatic build(input int n_in, o0_in, o1_in, o2_in);
        int n, lv[3], c[3], m, scale, b, a, s;
        n = clampl(n_in);
        lv[0] = clampl(o0_in); lv[1] = clampl(o1_in); lv[2] = clampl(o2_in);
        for (int k = 0; k < 3; k++)
            for (int j = 0; j < lv[k]; j++) begin
                c = '{0, 0, 0};
                c[k] = 32768 - j * rcp(lv[k]);
                c[(k + 1) % 3] = j * rcp(lv[k]);
                push(c[0], c[1], c[2], "R3");
            end
        m = n - 2;
        while (m >= 0) begin
            scale = m * rcp(n);
            b = ((32768 - scale) * 10922) >>> 15;
            a = 32768 - 2 * b;
            if (m == 0) begin
                push(a, b, b, "R7");
            end else begin
                s = ((a - b) * rcp(m)) >>> 15;
                for (int k = 0; k < 3; k++)
                    for (int j = 0; j < m; j++) begin
                        c = '{b, b, b};
                        c[k] = a - j * s;
                        c[(k + 1) % 3] = b + j * s;
                        push(c[0], c[1], c[2], (m == 1) ? "R7" : ((j == 0) ? "R5" : "R6"));
                    end
            end
            m -= 2;
        end
        exp_q[exp_q.size() - 1][48] = 1'b1;
    endtask

    // caller is positioned just after a falling edge
    task automatic run_patch(input int n, o0, o1, o2, input int mode,
                             input bit chain, input int cn, c0, c1, c2);
        bit done = 1'b0, stalled = 1'b0, sawreq = 1'b0, rdy;
        int cyc = 0;
        logic [48:0] held, got, expv;
        string tg;
        build(n, o0, o1, o2);
        req_inner = 7'(n); req_outer0 = 7'(o0); req_outer1 = 7'(o1); req_outer2 = 7'(o2);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (chain) begin
            req_inner = 7'(cn); req_outer0 = 7'(c0); req_outer1 = 7'(c1); req_outer2 = 7'(c2);
        end else begin
            req_valid = 1'b0;
        end
        check(req_ready == 1'b0, "R2", "req_ready after take", 64'(req_ready), 0);
        while (!done && cyc < 20000) begin
            case (mode)
                0: rdy = 1'b1;
                1: rdy = cyc[0];
                default: rdy = lfsr[0] | lfsr[3];
            endcase
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            vtx_ready = rdy;
            got = {vtx_eop, vtx_w, vtx_v, vtx_u};
            if (stalled)
                check(vtx_valid && got == held, "R10", "stalled vertex", 64'(got), 64'(held));
            if (req_ready) sawreq = 1'b1;
            stalled = 1'b0;
            if (vtx_valid) begin
                if (rdy) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "extra vertex", 64'(got), 0);
                    end else begin
                        expv = exp_q.pop_front();
                        tg = tag_q.pop_front();
                        check(got[47:0] == expv[47:0], tg, "vertex", 64'(got[47:0]), 64'(expv[47:0]));
                        check(got[48] == expv[48], "R9", "eop flag", 64'(got[48]), 64'(expv[48]));
                    end
                    if (vtx_eop) done = 1'b1;
                end else begin
                    stalled = 1'b1;
                    held = got;
                end
            end
            @(negedge clk);
            cyc++;
        end
        vtx_ready = 1'b0;
        check(done, "R8", "patch completed", 64'(done), 1);
        check(exp_q.size() == 0, "R8", "vertices left", 64'(exp_q.size()), 0);
        check(!sawreq, "R2", "ready seen mid-patch", 64'(sawreq), 0);
        check(req_ready == 1'b1, "R2", "ready after eop", 64'(req_ready), 1);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ol[4] = '{1, 2, 3, 5};
        int mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(vtx_valid == 1'b0, "R1", "vtx_valid after reset", 64'(vtx_valid), 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 1);

        // R7: all levels one gives only the three corners
        run_patch(1, 1, 1, 1, 0, 1'b0, 0, 0, 0, 0);
        // R4 R7: centre and single-triangle rings
        run_patch(2, 1, 1, 1, 1, 1'b0, 0, 0, 0, 0);
        run_patch(3, 2, 2, 2, 2, 1'b0, 0, 0, 0, 0);

        for (int n = 1; n <= 7; n++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 4; c++) begin
                        run_patch(n, ol[a], ol[b], ol[c], mode, 1'b0, 0, 0, 0, 0);
                        mode = (mode + 1) % 3;
                    end

        // R2: a request held during a patch waits for its end
        run_patch(6, 4, 3, 2, 2, 1'b1, 5, 2, 7, 1);
        run_patch(5, 2, 7, 1, 0, 1'b0, 0, 0, 0, 0);

        // R11: clamping of out-of-range levels
        tag_ovr = "R11";
        run_patch(0, 0, 0, 0, 1, 1'b0, 0, 0, 0, 0);
        run_patch(100, 70, 64, 127, 2, 1'b0, 0, 0, 0, 0);
        tag_ovr = "";

        // large levels
        run_patch(64, 64, 63, 1, 0, 1'b0, 0, 0, 0, 0);
        run_patch(63, 17, 33, 64, 1, 1'b0, 0, 0, 0, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule